// File: doc/BRIEF.md
# Handshake-Driven Frame Word Aligner

This block sits behind a serial capture front end. The front end shifts in bits, latches every completed byte, and flips a single handshake line once for each latched byte. The aligner has no access to a frame-sync signal. It finds frame boundaries by timing, on its own system clock, the spacing between handshake flips. During active data the flips are closely spaced. The idle stretch of each frame makes one interval much longer than the others, and that interval is taken as the frame break.

Once locked, the aligner numbers each transition of the frame from 1 to 12 and joins consecutive byte pairs into 16-bit words. It forwards only the first two words of each frame, each with a one-cycle strobe and a word index, and it drops the remaining four. If more transitions arrive than a frame can hold without an idle gap in between, the aligner declares loss of lock and stays silent until it sees the next long interval.

Top module: `frame_word_aligner`

## Requirements
- R1: While reset is asserted and immediately after it is released, `locked` and `word_valid` are both 0.
- R2: Every level change of `busy_in`, rising or falling, counts as one byte transition. The line passes through a `SYNC_STAGES`-flop synchronizer (default 2) before it is used.
- R3: The interval of a transition is the number of `clk` cycles since the previous transition. It is a long gap only when it is strictly greater than `gap_thresh`. An interval equal to `gap_thresh` is not a long gap.
- R4: The first transition after reset never counts as a long gap, however long the wait before it.
- R5: A transition with a long gap sets `locked` and becomes position 1 of a new frame. This holds even while the block is already locked, so it also resynchronizes a partial frame.
- R6: At odd positions the byte is the upper half of the word. At even positions it is the lower half. `word_data` = {byte at position 2w+1, byte at position 2w+2}.
- R7: Only words 0 (positions 1–2) and 1 (positions 3–4) are emitted. Each is emitted with a one-cycle `word_valid` pulse and `word_idx` equal to 0 or 1. The bytes at positions 5 to 12 produce no output.
- R8: When the block is locked at position 12, a further transition without a long gap clears `locked`. No word is emitted until the next long gap.
- R9: `word_valid` is never asserted while the block is unlocked.
- R10: `word_valid` for a word rises on the `SYNC_STAGES`+1-th rising `clk` edge after the `busy_in` change that carries that word's lower byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_in | input | 1 | Byte-ready handshake; toggles once per latched byte |
| byte_in | input | 8 | Latched byte from the capture front end |
| gap_thresh | input | 16 | Long-gap threshold in clk cycles |
| locked | output | 1 | Frame alignment acquired |
| word_valid | output | 1 | One-cycle strobe for a kept word |
| word_idx | output | 1 | Which kept word of the frame (0 or 1) |
| word_data | output | 16 | Assembled word, first byte in the upper half |

## Verification
The bench drives whole frames of twelve transitions with byte values computed from the frame and position numbers, so a swapped byte order or a wrong position count shows up in the data. The gap before each frame is swept across several values, and the threshold is swept as well; at each threshold, one interval exactly equal to it and one interval just above it separate the strict comparison from a non-strict one. A long wait before the very first transition shows whether the counter is armed at reset. A thirteenth transition, together with a truncated five-transition frame followed by a fresh gap, separates loss of lock from resynchronization. Every emitted word is also checked for its exact arrival cycle.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  // Odd positions (1, 3, ...) carry the upper byte of a word.
  function automatic bit pos_is_upper(input int unsigned pos);
    return (pos % 2) == 1;
  endfunction

  // Word number of a 1-based transition position.
  function automatic int unsigned word_of_pos(input int unsigned pos);
    return (pos - 1) / 2;
  endfunction

  function automatic bit pos_is_kept(input int unsigned pos, input int unsigned kept);
    return word_of_pos(pos) < kept;
  endfunction

  // Strict comparison: an interval equal to the threshold is still active data.
  function automatic bit interval_is_gap(input int unsigned interval, input int unsigned thresh);
    return interval > thresh;
  endfunction

endpackage

// File: rtl/fwa_toggle_sync.sv
module fwa_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  output logic tog
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= busy_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign tog = chain[STAGES-1] ^ last_q;

  // R2
  tog_follows_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog |=> (last_q != $past(last_q)));
endmodule

// File: rtl/fwa_interval_timer.sv
module fwa_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tog,
  input  logic [CNT_W-1:0] gap_thresh,
  output logic             gap_long
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (tog) begin
      cnt_q   <= CNT_W'(1);
      armed_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign gap_long = tog && armed_q &&
                    fwa_pkg::interval_is_gap(32'(cnt_q), 32'(gap_thresh));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog |=> (cnt_q == CNT_W'(1)));

  // R3
  armed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q != '0));
endmodule

// File: rtl/fwa_frame_tracker.sv
module fwa_frame_tracker #(
  parameter  int XFERS = 12,
  localparam int POS_W = $clog2(XFERS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tog,
  input  logic             gap_long,
  output logic             locked,
  output logic             accept,
  output logic [POS_W-1:0] cur_pos,
  output logic             overrun
);
  logic [POS_W-1:0] pos_q;
  logic             locked_q;
  logic             more_room;

  assign more_room = pos_q < POS_W'(XFERS);
  assign accept    = tog && (gap_long || (locked_q && more_room));
  assign overrun   = tog && !gap_long && locked_q && !more_room;
  assign cur_pos   = gap_long ? POS_W'(1) : pos_q + POS_W'(1);
  assign locked    = locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else if (gap_long) begin
      pos_q    <= POS_W'(1);
      locked_q <= 1'b1;
    end else if (overrun) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else if (accept) begin
      pos_q <= cur_pos;
    end
  end

  // R8
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(XFERS));

  // R8
  unlocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> (pos_q == '0));

  // R8
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !locked_q);

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(gap_long));
endmodule

// File: rtl/fwa_word_builder.sv
module fwa_word_builder #(
  parameter  int BYTE_W = 8,
  parameter  int KEPT   = 2,
  parameter  int POS_W  = 4,
  localparam int IDX_W  = (KEPT > 1) ? $clog2(KEPT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [POS_W-1:0]    cur_pos,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic                word_valid,
  output logic [IDX_W-1:0]    word_idx,
  output logic [2*BYTE_W-1:0] word_data
);
  logic [BYTE_W-1:0]   hi_q;
  logic                valid_q;
  logic [IDX_W-1:0]    idx_q;
  logic [2*BYTE_W-1:0] data_q;
  logic                is_upper;
  logic                is_kept;
  logic                emit;

  assign is_upper = fwa_pkg::pos_is_upper(32'(cur_pos));
  assign is_kept  = fwa_pkg::pos_is_kept(32'(cur_pos), KEPT);
  assign emit     = accept && !is_upper && is_kept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= emit;
      if (accept && is_upper) hi_q <= byte_in;
      if (emit) begin
        data_q <= {hi_q, byte_in};
        idx_q  <= IDX_W'(fwa_pkg::word_of_pos(32'(cur_pos)));
      end
    end
  end

  assign word_valid = valid_q;
  assign word_idx   = idx_q;
  assign word_data  = data_q;

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R7
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(accept));
endmodule

// File: rtl/frame_word_aligner.sv
module frame_word_aligner #(
  parameter  int SYNC_STAGES = 2,
  parameter  int CNT_W       = 16,
  parameter  int BYTE_W      = 8,
  parameter  int XFERS       = 12,
  parameter  int KEPT        = 2,
  localparam int POS_W       = $clog2(XFERS + 1),
  localparam int IDX_W       = (KEPT > 1) ? $clog2(KEPT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy_in,
  input  logic [BYTE_W-1:0]   byte_in,
  input  logic [CNT_W-1:0]    gap_thresh,
  output logic                locked,
  output logic                word_valid,
  output logic [IDX_W-1:0]    word_idx,
  output logic [2*BYTE_W-1:0] word_data
);
  logic             tog;
  logic             gap_long;
  logic             accept;
  logic             overrun;
  logic [POS_W-1:0] cur_pos;

  fwa_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .tog(tog)
  );

  fwa_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tog(tog), .gap_thresh(gap_thresh), .gap_long(gap_long)
  );

  fwa_frame_tracker #(.XFERS(XFERS)) u_track (
    .clk(clk), .rst_n(rst_n), .tog(tog), .gap_long(gap_long),
    .locked(locked), .accept(accept), .cur_pos(cur_pos), .overrun(overrun)
  );

  fwa_word_builder #(.BYTE_W(BYTE_W), .KEPT(KEPT), .POS_W(POS_W)) u_build (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cur_pos(cur_pos), .byte_in(byte_in),
    .word_valid(word_valid), .word_idx(word_idx), .word_data(word_data)
  );

  // R9
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> locked);

  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(overrun));
endmodule

// File: tb/frame_word_aligner_tb.sv
module frame_word_aligner_tb;
  localparam int SPACING = 10;
  localparam int LAT     = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy_in = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [15:0] gap_thresh = 16'd40;
  logic        locked;
  logic        word_valid;
  logic        word_idx;
  logic [15:0] word_data;

  frame_word_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .byte_in(byte_in),
    .gap_thresh(gap_thresh), .locked(locked), .word_valid(word_valid),
    .word_idx(word_idx), .word_data(word_data)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int bad = 0;
  int got_words = 0;
  int last_stamp = 0;
  logic [15:0] exp_data[$];
  logic        exp_idx[$];
  int          exp_cyc[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] d;
    logic        i;
    int          c;
    if (rst_n && word_valid) begin
      got_words++;
      if (exp_data.size() == 0) begin
        chk(1'b0, "R9", "unexpected word", word_data, -1);
      end else begin
        d = exp_data.pop_front();
        i = exp_idx.pop_front();
        c = exp_cyc.pop_front();
        chk(word_data == d, "R6", "word data", word_data, d);
        chk(word_idx == i, "R7", "word index", word_idx, i);
        chk(cyc == c, "R10", "word cycle", cyc, c);
      end
    end
  end

  function automatic logic [7:0] byte_of(input int f, input int k);
    return 8'((f * 53 + k * 29 + 7) % 256);
  endfunction

  // One handshake flip, w cycles after the previous one.
  task automatic tgl(input logic [7:0] b, input int w, output int stamp);
    @(negedge clk);
    while (cyc < last_stamp + w) @(negedge clk);
    byte_in = b;
    busy_in = ~busy_in;
    stamp = cyc;
    last_stamp = cyc;
  endtask

  task automatic send_frame(input int f, input int first_w, input int n, input bit expect_words);
    int st;
    for (int k = 1; k <= n; k++) begin
      tgl(byte_of(f, k), (k == 1) ? first_w : SPACING, st);
      if (expect_words && (k == 2 || k == 4)) begin
        exp_data.push_back({byte_of(f, k - 1), byte_of(f, k)});
        exp_idx.push_back(k == 4);
        exp_cyc.push_back(st + LAT);
      end
    end
  endtask

  task automatic settle(input string req);
    repeat (LAT + 3) @(negedge clk);
    chk(exp_data.size() == 0, req, "missing words", exp_data.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int st;
    int base;
    int thr_list[4] = '{12, 40, 63, 200};
    repeat (4) @(negedge clk);
    chk(locked == 1'b0, "R1", "locked in reset", locked, 0);
    chk(word_valid == 1'b0, "R1", "valid in reset", word_valid, 0);
    rst_n = 1'b1;
    last_stamp = cyc;
    repeat (2) @(negedge clk);
    chk(locked == 1'b0, "R1", "locked after reset", locked, 0);
    chk(word_valid == 1'b0, "R1", "valid after reset", word_valid, 0);

    // R4: long wait before the very first flip must not lock
    send_frame(1, 200, 12, 1'b0);
    settle("R4");
    chk(locked == 1'b0, "R4", "locked after first flip", locked, 0);
    // R9: more short flips while unlocked give nothing
    send_frame(2, SPACING, 12, 1'b0);
    settle("R9");
    chk(locked == 1'b0, "R9", "still unlocked", locked, 0);

    // R3/R5/R7: frames with a sweep of gap lengths, first one at thresh+1
    base = got_words;
    for (int f = 3; f <= 8; f++) begin
      send_frame(f, 41 + (f - 3) * 37, 12, 1'b1);
      settle("R7");
      chk(locked == 1'b1, "R5", "locked after gap", locked, 1);
    end
    chk(got_words - base == 12, "R2", "words from both edge directions", got_words - base, 12);

    // R3/R8: threshold sweep; interval == thresh is an overrun, thresh+1 relocks
    for (int t = 0; t < 4; t++) begin
      gap_thresh = 16'(thr_list[t]);
      tgl(8'hA5, thr_list[t], st);
      settle("R8");
      chk(locked == 1'b0, "R3", "equal interval not a gap", locked, 0);
      send_frame(30 + t, SPACING, 11, 1'b0);
      settle("R8");
      chk(locked == 1'b0, "R8", "silent after overrun", locked, 0);
      send_frame(40 + t, thr_list[t] + 1, 12, 1'b1);
      settle("R7");
      chk(locked == 1'b1, "R3", "thresh+1 is a gap", locked, 1);
    end

    // R5: truncated frame then a fresh gap resynchronizes
    gap_thresh = 16'd40;
    send_frame(50, 60, 5, 1'b1);
    settle("R5");
    chk(locked == 1'b1, "R5", "locked after partial", locked, 1);
    send_frame(51, 90, 12, 1'b1);
    settle("R5");
    chk(locked == 1'b1, "R5", "locked after resync", locked, 1);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule